// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register store of a small processor core. It has two banks of general registers. Each bank holds four 16-bit data registers, two address registers, a static base and a frame base. Beside the banks sit the registers shared by both: a vector table base, a user stack pointer, an interrupt stack pointer, the program counter and the flag word. A bank bit and a user-stack bit inside the flag word steer which bank and which stack pointer an access reaches.

The core reaches every register through one synchronous write port and one combinational read port. Both ports are addressed by a 5-bit register identifier. An identifier can name a whole register, a single byte of D0 or D1, a 32-bit concatenated pair, or one of two 64-bit quad views of the four data registers. A mode input picks 16-bit or 24-bit pointers. The mode sets the masks applied to address-class registers and to the program counter, on both write and read.

The block has no state machine. Its only sequential behaviour is register loading, and bank and stack selection follow the stored flag word.

Top module: `banked_regfile`

## Requirements
- R1: Reset (rst_n low) clears both banks and all shared registers, so every legal identifier reads 0 after reset.
- R2: Identifiers are encoded 0 D0, 1 D0 high byte, 2 D0 low byte, 3 D1, 4 D1 high byte, 5 D1 low byte, 6 D2, 7 pair D2:D0, 8 D3, 9 pair D3:D1, 10 X0, 11 X1, 12 pair X1:X0, 13 static base, 14 frame base, 15 vector base, 16 vector base low, 17 vector base high, 18 stack pointer alias, 19 user stack, 20 interrupt stack, 21 program counter, 22 flags, 23 quad D3:D1:D2:D0, 24 quad D3:D2:D1:D0. A full write to a data register stores wr_data[15:0], and a read returns it zero-extended.
- R3: A high-byte write stores wr_data[7:0] into bits 15:8 and keeps bits 7:0. A low-byte write stores wr_data[7:0] into bits 7:0 and keeps bits 15:8. A byte read returns that byte in rd_data[7:0] with all higher bits zero.
- R4: Pairs D2:D0 and D3:D1 place the first-named register in bits 31:16 and the second in bits 15:0, on read and on write. Pair X1:X0 uses the low 16 bits of each address register, and a pair write clears their bits 23:16.
- R5: Quad 23 maps bits 63:48, 47:32, 31:16 and 15:0 to D3, D1, D2, D0. Quad 24 maps the same slices to D3, D2, D1, D0.
- R6: Flag bit 4 selects bank 1 when set and bank 0 when clear, for identifiers 0 to 14, 23 and 24. A write to flags takes effect on the following cycle. The banks are independent of each other.
- R7: With ptr24 low, the address registers, both bases and both stack pointers are masked to 16 bits. With ptr24 high they are masked to 24 bits. The mask is applied on write and again on read.
- R8: The program counter is masked to 20 bits when ptr24 is low and to 24 bits when it is high, on write and on read.
- R9: Identifier 18 reaches the user stack pointer when flag bit 7 is set and the interrupt stack pointer otherwise.
- R10: The vector base reads as an 8-bit high part above a 16-bit low part. A full write splits wr_data[23:0] into the two parts. A low-part write keeps 16 bits and a high-part write keeps 8 bits.
- R11: A read of a register being written in the same cycle returns the value held before the write.
- R12: Identifiers 25 to 31 are illegal. An illegal read returns 0. An illegal write changes nothing. id_err is high whenever rd_id is illegal, or wr_en is high with an illegal wr_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr24 | input | 1 | Pointer mode: 1 selects 24-bit, 0 selects 16-bit |
| wr_en | input | 1 | Write strobe |
| wr_id | input | 5 | Write register identifier |
| wr_data | input | 64 | Write value, low bits used by narrow identifiers |
| rd_id | input | 5 | Read register identifier |
| rd_data | output | 64 | Read value, zero-extended |
| id_err | output | 1 | Illegal identifier on either port |

## Verification
The vector table writes one view of a register and reads back a different one. Full-write/byte-read, byte-write/full-read, pair-write/single-read and quad-write/other-quad-read each expose a different slicing or merge error. Oversized values written in 16-bit mode and then read in 24-bit mode show whether masking happens on write, on read or both. Flag writes that set the bank bit or the user-stack bit show that the selection follows the stored flags. A same-cycle write and read shows that reads return the old value. Writes to illegal identifiers are followed by reads of the registers they might have disturbed.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
    localparam int ID_W      = 5;
    localparam int DW        = 16;
    localparam int BW        = 8;
    localparam int PTR_W     = 24;
    localparam int NPTR_W    = 16;
    localparam int NPC_W     = 20;
    localparam int BUS_W     = 4 * DW;
    localparam int NBANK     = 2;
    localparam int BANK_BIT  = 4;
    localparam int USER_BIT  = 7;

    typedef enum logic [ID_W-1:0] {
        RID_D0, RID_D0H, RID_D0L,
        RID_D1, RID_D1H, RID_D1L,
        RID_D2, RID_D2D0,
        RID_D3, RID_D3D1,
        RID_X0, RID_X1, RID_X1X0,
        RID_SB, RID_FB,
        RID_VT, RID_VTL, RID_VTH,
        RID_SP, RID_USP, RID_ISP,
        RID_PC, RID_FLG,
        RID_Q3120, RID_Q3210
    } reg_id_e;

    localparam logic [ID_W-1:0] LAST_ID = ID_W'(RID_Q3210);

    typedef struct packed {
        logic [DW-1:0]    d0, d1, d2, d3;
        logic [PTR_W-1:0] x0, x1, sbase, fbase;
    } bank_t;

    function automatic logic id_legal(input logic [ID_W-1:0] id);
        return id <= LAST_ID;
    endfunction
endpackage

// File: rtl/rbf_bank.sv
module rbf_bank
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_id_e          wid,
    input  logic [BUS_W-1:0] wdat,
    input  logic [PTR_W-1:0] amask,
    output bank_t            st
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (we) begin
            case (wid)
                RID_D0:   st.d0 <= wdat[DW-1:0];
                RID_D0H:  st.d0[DW-1:BW] <= wdat[BW-1:0];
                RID_D0L:  st.d0[BW-1:0] <= wdat[BW-1:0];
                RID_D1:   st.d1 <= wdat[DW-1:0];
                RID_D1H:  st.d1[DW-1:BW] <= wdat[BW-1:0];
                RID_D1L:  st.d1[BW-1:0] <= wdat[BW-1:0];
                RID_D2:   st.d2 <= wdat[DW-1:0];
                RID_D2D0: begin
                    st.d0 <= wdat[DW-1:0];
                    st.d2 <= wdat[2*DW-1:DW];
                end
                RID_D3:   st.d3 <= wdat[DW-1:0];
                RID_D3D1: begin
                    st.d1 <= wdat[DW-1:0];
                    st.d3 <= wdat[2*DW-1:DW];
                end
                RID_X0:   st.x0 <= wdat[PTR_W-1:0] & amask;
                RID_X1:   st.x1 <= wdat[PTR_W-1:0] & amask;
                RID_X1X0: begin
                    st.x0 <= PTR_W'(wdat[DW-1:0]);
                    st.x1 <= PTR_W'(wdat[2*DW-1:DW]);
                end
                RID_SB:   st.sbase <= wdat[PTR_W-1:0] & amask;
                RID_FB:   st.fbase <= wdat[PTR_W-1:0] & amask;
                RID_Q3120: begin
                    st.d3 <= wdat[4*DW-1:3*DW];
                    st.d1 <= wdat[3*DW-1:2*DW];
                    st.d2 <= wdat[2*DW-1:DW];
                    st.d0 <= wdat[DW-1:0];
                end
                RID_Q3210: begin
                    st.d3 <= wdat[4*DW-1:3*DW];
                    st.d2 <= wdat[3*DW-1:2*DW];
                    st.d1 <= wdat[2*DW-1:DW];
                    st.d0 <= wdat[DW-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rbf_shared.sv
module rbf_shared
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_id_e          wid,
    input  logic [BUS_W-1:0] wdat,
    input  logic [PTR_W-1:0] amask,
    input  logic [PTR_W-1:0] pmask,
    output logic [DW-1:0]    vt_lo,
    output logic [BW-1:0]    vt_hi,
    output logic [PTR_W-1:0] usp,
    output logic [PTR_W-1:0] isp,
    output logic [PTR_W-1:0] pc,
    output logic [DW-1:0]    flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vt_lo <= '0;
            vt_hi <= '0;
            usp   <= '0;
            isp   <= '0;
            pc    <= '0;
            flags <= '0;
        end else if (we) begin
            case (wid)
                RID_VT: begin
                    vt_lo <= wdat[DW-1:0];
                    vt_hi <= wdat[DW+BW-1:DW];
                end
                RID_VTL: vt_lo <= wdat[DW-1:0];
                RID_VTH: vt_hi <= wdat[BW-1:0];
                RID_SP: begin
                    if (flags[USER_BIT]) usp <= wdat[PTR_W-1:0] & amask;
                    else                 isp <= wdat[PTR_W-1:0] & amask;
                end
                RID_USP: usp   <= wdat[PTR_W-1:0] & amask;
                RID_ISP: isp   <= wdat[PTR_W-1:0] & amask;
                RID_PC:  pc    <= wdat[PTR_W-1:0] & pmask;
                RID_FLG: flags <= wdat[DW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr24,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [ID_W-1:0]  rd_id,
    output logic [BUS_W-1:0] rd_data,
    output logic             id_err
);
    logic [PTR_W-1:0] amask, pmask;
    logic             wr_ok;
    logic             bank_sel;
    bank_t            bank_q [NBANK];
    bank_t            cur;
    logic [DW-1:0]    vt_lo;
    logic [BW-1:0]    vt_hi;
    logic [PTR_W-1:0] usp_q, isp_q, pc_q;
    logic [DW-1:0]    flags_q;
    reg_id_e          rid;

    assign amask    = {{(PTR_W-NPTR_W){ptr24}}, {NPTR_W{1'b1}}};
    assign pmask    = {{(PTR_W-NPC_W){ptr24}}, {NPC_W{1'b1}}};
    assign wr_ok    = wr_en && id_legal(wr_id);
    assign bank_sel = flags_q[BANK_BIT];
    assign id_err   = !id_legal(rd_id) || (wr_en && !id_legal(wr_id));
    assign rid      = reg_id_e'(rd_id);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rbf_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok && (bank_sel == b[0])),
            .wid   (reg_id_e'(wr_id)),
            .wdat  (wr_data),
            .amask (amask),
            .st    (bank_q[b])
        );
    end

    rbf_shared u_shared (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .wid   (reg_id_e'(wr_id)),
        .wdat  (wr_data),
        .amask (amask),
        .pmask (pmask),
        .vt_lo (vt_lo),
        .vt_hi (vt_hi),
        .usp   (usp_q),
        .isp   (isp_q),
        .pc    (pc_q),
        .flags (flags_q)
    );

    assign cur = bank_q[bank_sel];

    always_comb begin
        rd_data = '0;
        case (rid)
            RID_D0:    rd_data[DW-1:0] = cur.d0;
            RID_D0H:   rd_data[BW-1:0] = cur.d0[DW-1:BW];
            RID_D0L:   rd_data[BW-1:0] = cur.d0[BW-1:0];
            RID_D1:    rd_data[DW-1:0] = cur.d1;
            RID_D1H:   rd_data[BW-1:0] = cur.d1[DW-1:BW];
            RID_D1L:   rd_data[BW-1:0] = cur.d1[BW-1:0];
            RID_D2:    rd_data[DW-1:0] = cur.d2;
            RID_D2D0:  rd_data[2*DW-1:0] = {cur.d2, cur.d0};
            RID_D3:    rd_data[DW-1:0] = cur.d3;
            RID_D3D1:  rd_data[2*DW-1:0] = {cur.d3, cur.d1};
            RID_X0:    rd_data[PTR_W-1:0] = cur.x0 & amask;
            RID_X1:    rd_data[PTR_W-1:0] = cur.x1 & amask;
            RID_X1X0:  rd_data[2*DW-1:0] = {cur.x1[DW-1:0], cur.x0[DW-1:0]};
            RID_SB:    rd_data[PTR_W-1:0] = cur.sbase & amask;
            RID_FB:    rd_data[PTR_W-1:0] = cur.fbase & amask;
            RID_VT:    rd_data[DW+BW-1:0] = {vt_hi, vt_lo};
            RID_VTL:   rd_data[DW-1:0] = vt_lo;
            RID_VTH:   rd_data[BW-1:0] = vt_hi;
            RID_SP:    rd_data[PTR_W-1:0] = (flags_q[USER_BIT] ? usp_q : isp_q) & amask;
            RID_USP:   rd_data[PTR_W-1:0] = usp_q & amask;
            RID_ISP:   rd_data[PTR_W-1:0] = isp_q & amask;
            RID_PC:    rd_data[PTR_W-1:0] = pc_q & pmask;
            RID_FLG:   rd_data[DW-1:0] = flags_q;
            RID_Q3120: rd_data = {cur.d3, cur.d1, cur.d2, cur.d0};
            RID_Q3210: rd_data = {cur.d3, cur.d2, cur.d1, cur.d0};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import rbf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ptr24,
    input logic             wr_en,
    input logic [ID_W-1:0]  wr_id,
    input logic [BUS_W-1:0] wr_data,
    input logic [ID_W-1:0]  rd_id,
    input logic [BUS_W-1:0] rd_data,
    input logic             id_err,
    input logic [DW-1:0]    flags_q,
    input logic [PTR_W-1:0] pc_q
);
    p_flags_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_W'(RID_FLG)) |=> flags_q == $past(wr_data[DW-1:0]));

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_id == ID_W'(RID_FLG)) |=> $stable(flags_q));

    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_W'(RID_PC)) |=>
        pc_q == ($past(wr_data[PTR_W-1:0]) & ($past(ptr24) ? 24'hFFFFFF : 24'h0FFFFF)));

    p_pc_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id == ID_W'(RID_PC) && !ptr24) |-> rd_data[BUS_W-1:NPC_W] == '0);

    p_addr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id == ID_W'(RID_X0) && !ptr24) |-> rd_data[BUS_W-1:NPTR_W] == '0);

    p_byte_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id == ID_W'(RID_D0H) || rd_id == ID_W'(RID_D1L)) |-> rd_data[BUS_W-1:BW] == '0);

    p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !id_legal(wr_id)) |=> ($stable(flags_q) && $stable(pc_q)));

    p_illegal_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !id_legal(rd_id) |-> (id_err && rd_data == '0));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr24   (ptr24),
    .wr_en   (wr_en),
    .wr_id   (wr_id),
    .wr_data (wr_data),
    .rd_id   (rd_id),
    .rd_data (rd_data),
    .id_err  (id_err),
    .flags_q (flags_q),
    .pc_q    (pc_q)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr24 = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_id = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_id = '0;
    logic [63:0] rd_data;
    logic        id_err;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .ptr24(ptr24), .wr_en(wr_en),
        .wr_id(wr_id), .wr_data(wr_data), .rd_id(rd_id),
        .rd_data(rd_data), .id_err(id_err)
    );

    always #2 clk = ~clk;

    // entry: req[3:0] | wr id[4:0] | wr data[63:0] | rd id[4:0] | expected[63:0]
    localparam int NV = 16;
    localparam logic [141:0] VEC [NV] = '{
        {4'd2,  5'd0,  64'h1234,             5'd0,  64'h1234},             // R2
        {4'd3,  5'd1,  64'h00AB,             5'd0,  64'hAB34},             // R3
        {4'd3,  5'd2,  64'h11CD,             5'd0,  64'hABCD},             // R3
        {4'd3,  5'd2,  64'h0099,             5'd1,  64'h00AB},             // R3
        {4'd3,  5'd3,  64'h5566,             5'd5,  64'h0066},             // R3
        {4'd4,  5'd7,  64'h1111_2222,        5'd6,  64'h1111},             // R4
        {4'd4,  5'd9,  64'hAAAA_BBBB,        5'd9,  64'hAAAA_BBBB},        // R4
        {4'd4,  5'd12, 64'h1234_5678,        5'd10, 64'h5678},             // R4
        {4'd5,  5'd23, 64'h0001_0002_0003_0004, 5'd24, 64'h0001_0003_0002_0004}, // R5
        {4'd7,  5'd10, 64'hFFAB_CDEF,        5'd10, 64'hCDEF},             // R7
        {4'd8,  5'd21, 64'h00FF_FFFF,        5'd21, 64'h000F_FFFF},        // R8
        {4'd10, 5'd15, 64'h00AB_CDEF,        5'd17, 64'h00AB},             // R10
        {4'd10, 5'd17, 64'h01FF,             5'd15, 64'h00FF_CDEF},        // R10
        {4'd10, 5'd16, 64'h1234,             5'd15, 64'h00FF_1234},        // R10
        {4'd9,  5'd18, 64'h4321,             5'd20, 64'h4321},             // R9
        {4'd7,  5'd13, 64'h0012_7777,        5'd13, 64'h7777}              // R7
    };

    task automatic wr(input logic [4:0] id, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_id = id; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] id, input logic [63:0] exp, input string tag);
        @(negedge clk);
        rd_id = id;
        #1 check(tag, rd_data, exp);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'd0,  64'h0, "R1 D0");
        rd(5'd22, 64'h0, "R1 flags");
        rd(5'd21, 64'h0, "R1 pc");
        rd(5'd24, 64'h0, "R1 quad");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][137:133], VEC[i][132:69]);
            rd(VEC[i][68:64], VEC[i][63:0], $sformatf("R%0d row %0d", VEC[i][141:138], i));
        end

        // R6 bank switch: bank 1 starts empty, bank 0 keeps D0 = 0x0004
        wr(5'd22, 64'h0010);
        rd(5'd0, 64'h0, "R6 bank1 empty");
        wr(5'd0, 64'hBEEF);
        rd(5'd0, 64'hBEEF, "R6 bank1 write");
        wr(5'd22, 64'h0000);
        rd(5'd0, 64'h0004, "R6 bank0 kept");

        // R9 stack alias follows user bit
        wr(5'd22, 64'h0080);
        wr(5'd18, 64'h5555);
        rd(5'd19, 64'h5555, "R9 usp via alias");
        rd(5'd20, 64'h4321, "R9 isp untouched");
        rd(5'd18, 64'h5555, "R9 alias read");

        // R7 / R8 pointer mode
        @(negedge clk); ptr24 = 1'b1;
        rd(5'd10, 64'hCDEF, "R7 masked on write");
        wr(5'd10, 64'hFFAB_CDEF);
        rd(5'd10, 64'hAB_CDEF, "R7 24-bit");
        wr(5'd21, 64'h00FF_FFFF);
        rd(5'd21, 64'hFF_FFFF, "R8 24-bit pc");
        @(negedge clk); ptr24 = 1'b0;
        #1 rd_id = 5'd21;
        #0.5 check("R8 pc read mask", rd_data, 64'h0F_FFFF);
        rd(5'd10, 64'hCDEF, "R7 read mask");

        // R11 read during write: D1 holds 0x0002
        @(negedge clk);
        wr_en = 1'b1; wr_id = 5'd3; wr_data = 64'h9999; rd_id = 5'd3;
        #1 check("R11 old value", rd_data, 64'h0002);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R11 new value", rd_data, 64'h9999);

        // R12 illegal identifiers
        rd(5'd25, 64'h0, "R12 illegal read data");
        check("R12 err on read", {63'h0, id_err}, 64'h1);
        @(negedge clk);
        wr_en = 1'b1; wr_id = 5'd30; wr_data = '1; rd_id = 5'd0;
        #1 check("R12 err on write", {63'h0, id_err}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R12 no err legal", {63'h0, id_err}, 64'h0);
        rd(5'd22, 64'h0080, "R12 flags unchanged");
        rd(5'd0,  64'h0004, "R12 D0 unchanged");
        rd(5'd21, 64'h0F_FFFF, "R12 pc unchanged");

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'd0,  64'h0, "R1 D0 after reset");
        rd(5'd22, 64'h0, "R1 flags after reset");
        rd(5'd19, 64'h0, "R1 usp after reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule